// File: doc/BRIEF.md
# Status Register and Write-Protect Unit

This unit keeps the eight-bit status register of a serial nonvolatile memory and decides whether writes are allowed. It takes decoded command events from the serial engine: the write-enable set and clear commands, the start of a status-write command, its data byte, and the chip-select release that ends a status write or a memory write. It also takes the level of the write-protect pin. From these it presents the status byte for a status read, a flag telling whether a status write would be accepted now, and a flag telling whether a memory write to a given address would be accepted.

The register holds a protect-enable bit, three spare bits, a two-bit protected-zone selector and the write-enable latch. Bit 0 always reads 0. A status write needs the latch to be set, and it is refused when the protect-enable bit is 1 while the write-protect pin is low. The pin level is captured when the status-write command starts, and that captured level governs the data byte that follows. The zone selector fences off none, the top quarter, the top half or all of the address space for memory writes. All state comes out of reset as zero, which stands in for real nonvolatile storage.

Top module: `spr_status_unit`

## Requirements
- R1: The status byte has the protect-enable bit at bit 7, spare bits at 6:4, the zone selector at 3:2 (bit 3 high, bit 2 low), the write-enable latch at bit 1, and a constant 0 at bit 0.
- R2: While reset is held and on the first cycle after it, the status byte is 0x00 and both permission flags are 0.
- R3: A write-enable set event makes bit 1 read 1 from the next cycle; a write-enable clear event makes it read 0 from the next cycle, and wins when both arrive together.
- R4: The end of a status-write command and the end of a memory-write command each clear the latch on the next cycle, and each wins over a set event in the same cycle.
- R5: An accepted status-write data byte loads its bits 7:2 into status bits 7:2 on the next cycle; its bits 1:0 are ignored.
- R6: A status-write data byte arriving while the latch is 0 leaves status bits 7:2 unchanged.
- R7: When the protect-enable bit is 1 and the pin (active-low, 0 = protect) was 0 at the start event of the status write, the data byte leaves status bits 7:2 unchanged; a pin change between start and data has no effect on this decision.
- R8: The status-write-permitted output is 1 exactly when the latch is 1 and not (protect-enable is 1 and the pin is currently 0).
- R9: The memory-write-permitted output is 1 exactly when the latch is 1 and the address lies outside the zone: selector 00 none, 01 addresses 0x6000 to 0x7FFF, 10 addresses 0x4000 to 0x7FFF, 11 every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, stands in for power-up |
| ev_wren | input | 1 | Write-enable set command recognised (one-cycle pulse) |
| ev_wrdi | input | 1 | Write-enable clear command recognised (one-cycle pulse) |
| ev_wrsr_start | input | 1 | Status-write command recognised; captures the pin level |
| ev_wrsr_data | input | 1 | Status-write data byte valid |
| wrsr_byte | input | 8 | Status-write data byte |
| ev_wrsr_end | input | 1 | Chip select released after a status write |
| ev_write_end | input | 1 | Chip select released after a memory write |
| wp_n | input | 1 | Write-protect pin, 0 = protect |
| chk_addr | input | ADDR_W | Memory address whose write permission is queried |
| status_byte | output | 8 | Status byte for a status read |
| sr_write_ok | output | 1 | A status write would be accepted now |
| mem_write_ok | output | 1 | A memory write to chk_addr would be accepted now |

## Verification
The assertions assume each event input is a clean one-cycle pulse from the serial engine, that a status-write data byte follows its own start event, and that a start and a data byte never share a cycle. The stimulus drives every command as such a sequence of single-cycle pulses, away from the clock edge, while a behavioural model in the bench predicts all three outputs every cycle. Simultaneous set and clear events are offered on purpose, since the clearing priority is specified; start and data are always kept in separate cycles.

// File: rtl/spr_pkg.sv
package spr_pkg;

    // Writable configuration portion of the status register, bits 7:2
    typedef struct packed {
        logic       wpen;
        logic [2:0] spare;
        logic [1:0] bp;
    } spr_cfg_t;

    localparam int CFG_W = $bits(spr_cfg_t);

    function automatic logic [7:0] spr_pack(input spr_cfg_t cfg, input logic wel);
        return {cfg, wel, 1'b0};
    endfunction

endpackage

// File: rtl/spr_wel_latch.sv
module spr_wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_cmd_i,
    input  logic clr_sr_end_i,
    input  logic clr_mem_end_i,
    output logic wel_o
);

    typedef struct packed {
        logic wel;
    } wel_st_t;

    wel_st_t st_d, st_q;
    logic    any_clr;

    always_comb begin
        st_d    = st_q;
        any_clr = clr_cmd_i | clr_sr_end_i | clr_mem_end_i;
        if (any_clr) begin
            st_d.wel = 1'b0;
        end else if (set_i) begin
            st_d.wel = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wel_o = st_q.wel;

    AST_WEL_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd_i || clr_sr_end_i || clr_mem_end_i) |=> !wel_o); // R4
    AST_WEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !clr_cmd_i && !clr_sr_end_i && !clr_mem_end_i) |=> wel_o); // R3
    AST_WEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_cmd_i && !clr_sr_end_i && !clr_mem_end_i) |=> $stable(wel_o)); // R3

endmodule

// File: rtl/spr_cfg_bits.sv
module spr_cfg_bits
    import spr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wel_i,
    input  logic     start_i,
    input  logic     wp_n_i,
    input  logic     data_vld_i,
    input  logic [7:0] data_i,
    output spr_cfg_t cfg_o,
    output logic     unlocked_now_o
);

    typedef struct packed {
        spr_cfg_t cfg;
        logic     wp_held;
    } cfg_st_t;

    cfg_st_t st_d, st_q;
    logic    locked;
    logic    unused_low;

    assign unused_low = ^data_i[1:0];

    always_comb begin
        st_d   = st_q;
        locked = st_q.cfg.wpen & ~st_q.wp_held;
        if (start_i) begin
            st_d.wp_held = wp_n_i;
        end
        if (data_vld_i && wel_i && !locked) begin
            st_d.cfg = spr_cfg_t'(data_i[7:2]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg     <= '0;
            st_q.wp_held <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o          = st_q.cfg;
    assign unlocked_now_o = ~(st_q.cfg.wpen & ~wp_n_i);

    AST_NO_LOAD_WITHOUT_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        !wel_i |=> $stable(cfg_o)); // R6
    AST_LOCK_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld_i && cfg_o.wpen && !st_q.wp_held) |=> $stable(cfg_o)); // R7
    AST_LOAD_TAKES_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (data_vld_i && wel_i && !(cfg_o.wpen && !st_q.wp_held))
        |=> (cfg_o == spr_cfg_t'($past(data_i[7:2])))); // R5

endmodule

// File: rtl/spr_zone_gate.sv
module spr_zone_gate #(
    parameter int ADDR_W = 15
) (
    input  logic [1:0]        bp_i,
    input  logic              wel_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              ok_o
);

    localparam logic [ADDR_W-1:0] QUARTER_BASE = ADDR_W'(3) << (ADDR_W - 2);
    localparam logic [ADDR_W-1:0] HALF_BASE    = ADDR_W'(1) << (ADDR_W - 1);

    logic fenced;

    always_comb begin
        unique case (bp_i)
            2'b00:   fenced = 1'b0;
            2'b01:   fenced = (addr_i >= QUARTER_BASE);
            2'b10:   fenced = (addr_i >= HALF_BASE);
            default: fenced = 1'b1;
        endcase
        ok_o = wel_i & ~fenced;
    end

endmodule

// File: rtl/spr_status_unit.sv
module spr_status_unit
    import spr_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_wren,
    input  logic              ev_wrdi,
    input  logic              ev_wrsr_start,
    input  logic              ev_wrsr_data,
    input  logic [7:0]        wrsr_byte,
    input  logic              ev_wrsr_end,
    input  logic              ev_write_end,
    input  logic              wp_n,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        status_byte,
    output logic              sr_write_ok,
    output logic              mem_write_ok
);

    logic     wel_q;
    spr_cfg_t cfg_q;
    logic     unlocked_now;

    spr_wel_latch u_wel (
        .clk           (clk),
        .rst_n         (rst_n),
        .set_i         (ev_wren),
        .clr_cmd_i     (ev_wrdi),
        .clr_sr_end_i  (ev_wrsr_end),
        .clr_mem_end_i (ev_write_end),
        .wel_o         (wel_q)
    );

    spr_cfg_bits u_cfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .wel_i          (wel_q),
        .start_i        (ev_wrsr_start),
        .wp_n_i         (wp_n),
        .data_vld_i     (ev_wrsr_data),
        .data_i         (wrsr_byte),
        .cfg_o          (cfg_q),
        .unlocked_now_o (unlocked_now)
    );

    spr_zone_gate #(.ADDR_W(ADDR_W)) u_zone (
        .bp_i   (cfg_q.bp),
        .wel_i  (wel_q),
        .addr_i (chk_addr),
        .ok_o   (mem_write_ok)
    );

    assign status_byte = spr_pack(cfg_q, wel_q);
    assign sr_write_ok = wel_q & unlocked_now;

    AST_FULL_ZONE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[3:2] == 2'b11) |-> !mem_write_ok); // R9
    AST_MEM_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_write_ok |-> status_byte[1]); // R9
    AST_SR_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[7] && !wp_n) |-> !sr_write_ok); // R8
    AST_BIT0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ev_wrsr_data) |-> !status_byte[0]); // R1

endmodule

// File: tb/tb_spr_status_unit.sv
module tb_spr_status_unit;

    localparam int AW = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_wren = 0, ev_wrdi = 0, ev_wrsr_start = 0, ev_wrsr_data = 0;
    logic          ev_wrsr_end = 0, ev_write_end = 0, wp_n = 1'b1;
    logic [7:0]    wrsr_byte = '0;
    logic [AW-1:0] chk_addr = '0;
    logic [7:0]    status_byte;
    logic          sr_write_ok, mem_write_ok;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string tag = "R2";

    // behavioural reference state
    bit m_wel, m_wpen, m_wph;
    bit [2:0] m_spare;
    bit [1:0] m_bp;

    spr_status_unit #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ev_wren(ev_wren), .ev_wrdi(ev_wrdi),
        .ev_wrsr_start(ev_wrsr_start), .ev_wrsr_data(ev_wrsr_data),
        .wrsr_byte(wrsr_byte), .ev_wrsr_end(ev_wrsr_end),
        .ev_write_end(ev_write_end), .wp_n(wp_n), .chk_addr(chk_addr),
        .status_byte(status_byte), .sr_write_ok(sr_write_ok),
        .mem_write_ok(mem_write_ok)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_wel = 0; m_wpen = 0; m_spare = 0; m_bp = 0; m_wph = 1;
        end else begin
            bit lock;
            lock = m_wpen && !m_wph;
            if (ev_wrsr_data && m_wel && !lock) begin
                m_wpen  = wrsr_byte[7];
                m_spare = wrsr_byte[6:4];
                m_bp    = wrsr_byte[3:2];
            end
            if (ev_wrsr_start) m_wph = wp_n;
            if (ev_wrdi || ev_wrsr_end || ev_write_end) m_wel = 0;
            else if (ev_wren) m_wel = 1;
        end
    end

    function automatic bit exp_mem_ok();
        int a;
        bit fenced;
        a = int'(chk_addr);
        case (m_bp)
            2'd0: fenced = 0;
            2'd1: fenced = (a >= 24576);
            2'd2: fenced = (a >= 16384);
            default: fenced = 1;
        endcase
        return m_wel && !fenced && rst_n;
    endfunction

    task automatic cmp(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, what, act, exp, cycles);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        cmp("status_byte", int'(status_byte),
            int'({m_wpen, m_spare, m_bp, m_wel, 1'b0}));
        cmp("sr_write_ok", int'(sr_write_ok), int'(m_wel && !(m_wpen && !wp_n)));
        cmp("mem_write_ok", int'(mem_write_ok), int'(exp_mem_ok()));
    endtask

    task automatic pulse_wren();
        ev_wren = 1; step(); ev_wren = 0;
    endtask

    task automatic wrsr(logic [7:0] b, logic wp_start, logic wp_data);
        wp_n = wp_start; ev_wrsr_start = 1; step(); ev_wrsr_start = 0;
        wp_n = wp_data; wrsr_byte = b; ev_wrsr_data = 1; step(); ev_wrsr_data = 0;
        ev_wrsr_end = 1; step(); ev_wrsr_end = 0;
        step();
    endtask

    task automatic sweep();
        logic [AW-1:0] pts [8] = '{15'h0000, 15'h3FFF, 15'h4000, 15'h5FFF,
                                   15'h6000, 15'h7FFF, 15'h2000, 15'h6ABC};
        for (int i = 0; i < 8; i++) begin
            chk_addr = pts[i];
            step();
        end
    endtask

    initial begin
        #2;
        tag = "R2";
        repeat (3) step();
        rst_n = 1;
        step();

        tag = "R9";
        sweep();                      // latch clear: no memory write

        tag = "R3";
        pulse_wren();
        tag = "R9";
        sweep();                      // zone 00: all allowed

        tag = "R5";
        wrsr(8'h7F, 1, 1);            // -> 0x7C, low bits ignored, latch cleared at end
        tag = "R1";
        step();
        tag = "R4";
        pulse_wren();
        tag = "R9";
        sweep();                      // zone 11: all blocked

        tag = "R5";
        wrsr(8'h24, 1, 1);            // zone 01
        pulse_wren();
        tag = "R9";
        sweep();
        tag = "R5";
        wrsr(8'h4B, 1, 1);            // zone 10, low bits 11 ignored
        pulse_wren();
        tag = "R9";
        sweep();

        tag = "R3";
        ev_wrdi = 1; step(); ev_wrdi = 0;
        tag = "R6";
        wrsr(8'hFC, 1, 1);            // latch clear: no change

        tag = "R7";
        pulse_wren();
        wrsr(8'h80, 1, 1);            // set protect-enable
        pulse_wren();
        wp_n = 0;
        tag = "R8";
        step();
        tag = "R7";
        wrsr(8'h0C, 0, 0);            // blocked
        pulse_wren();
        wrsr(8'h84, 1, 0);            // pin high at start: accepted
        pulse_wren();
        wrsr(8'h00, 0, 1);            // pin low at start: blocked
        tag = "R8";
        pulse_wren();
        wp_n = 0; step();
        wp_n = 1; step();

        tag = "R4";
        ev_write_end = 1; step(); ev_write_end = 0;
        step();
        ev_wren = 1; ev_write_end = 1; step(); ev_wren = 0; ev_write_end = 0;
        ev_wren = 1; ev_wrsr_end = 1; step(); ev_wren = 0; ev_wrsr_end = 0;
        tag = "R3";
        ev_wren = 1; ev_wrdi = 1; step(); ev_wren = 0; ev_wrdi = 0;
        pulse_wren();
        step();

        tag = "R5";
        wrsr(8'h00, 1, 1);            // unlock back to zero
        step();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule